// File: doc/BRIEF.md
# Serial-Wire Debug Register Access Sequencer

This block runs one complete register access on a two-wire serial debug link, one bit period per clock cycle. A single `start` pulse, with the access fields beside it, makes the block send an 8-bit request header, release the data line for a turnaround, and collect a 3-bit acknowledge from the target. When the acknowledge is OK, it then moves a 33-bit data frame (32 data bits and an even-parity bit) in the direction the read/write flag chose. Every access, whether or not it succeeds, ends with a one-cycle `done` pulse. At that point the acknowledge, the read data and a parity-error flag are on the result ports.

The data line is split into `dio_out`, `dio_oe` and `dio_in` so that a pad or an outer serializer can be wrapped around it. The turnaround length can be set per access from one to four bit periods. Any retry on WAIT or FAULT, and any clearing of sticky errors, is left to the logic that drives `start`.

Top module: `swd_access_seq`

## Requirements
- R1: In the 8 bit periods that begin in the cycle after `start` is accepted, `dio_oe` is 1 and `dio_out` carries the request header LSB first. Bit 0 is 1, bit 1 is `ap_sel`, bit 2 is `rd_nwr`, bit 3 is `addr[0]`, bit 4 is `addr[1]`, bit 6 is 0 and bit 7 is 1.
- R2: Header bit 5 is 1 exactly when bits 1 to 4 hold an odd number of ones, so that bits 1 to 5 together have even parity.
- R3: Right after the header, `dio_oe` is 0 for `trn_len`+1 bit periods.
- R4: In the next 3 bit periods, `dio_oe` is 0 and `dio_in` is sampled as the acknowledge, LSB first. The value is shown on `ack` from the `done` cycle onward. 3'b001 is OK, 3'b010 is WAIT and 3'b100 is FAULT.
- R5: On a write (`rd_nwr`=0) with an OK acknowledge, `dio_oe` is 0 for `trn_len`+1 periods. Then `dio_oe` is 1 for 33 periods, sending the `wdata` captured at start LSB first, followed by a bit that is 1 when that data has an odd number of ones.
- R6: On a read (`rd_nwr`=1) with an OK acknowledge, `dio_in` is sampled for 33 periods with `dio_oe` at 0. The first 32 bits, LSB first, appear on `rdata` at `done`. After them, `dio_oe` stays 0 for `trn_len`+1 more periods.
- R7: At `done` of an OK read, `par_err` is 1 when received bit 32 differs from the odd-ones parity of the 32 received data bits. Every other access leaves `par_err` at 0.
- R8: Any acknowledge other than 3'b001 skips the data phase. The block holds `dio_oe` at 0 for `trn_len`+1 periods and then ends the access, leaving `rdata` unchanged.
- R9: `busy` is 1 from the first header period through the last bit period of the access. `done` is 1 for exactly one cycle, the cycle after the last bit period, and `busy` is 0 in that cycle.
- R10: A `start` pulse while `busy` is 1 is ignored, and the current access continues unchanged.
- R11: While idle, the block drives the line low (`dio_oe`=1, `dio_out`=0). After reset, `busy`, `done`, `ack`, `rdata` and `par_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit period per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an access (accepted only while idle) |
| ap_sel | input | 1 | Selects the access-port register bank (1) or debug-port bank (0) |
| rd_nwr | input | 1 | 1 for read, 0 for write |
| addr | input | 2 | Register address bits A[3:2] |
| wdata | input | 32 | Write data, captured at start |
| trn_len | input | 2 | Turnaround length minus one, in bit periods |
| dio_in | input | 1 | Data line as seen from the target |
| dio_out | output | 1 | Data line value driven by the host |
| dio_oe | output | 1 | Host drives the data line when 1 |
| busy | output | 1 | Access in progress |
| ack | output | 3 | Last acknowledge received |
| rdata | output | 32 | Last read data with OK acknowledge |
| par_err | output | 1 | Read parity mismatch on the last access |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The cases that are hardest to reach from the ports all depend on the target's response rather than on the host's request. These are a read whose parity bit is wrong, a non-OK or malformed acknowledge that has to cut the data phase short, and a second `start` that arrives in the middle of an access. The bench acts as the target. Each access picks its acknowledge and read frame from a seeded random draw, weighted toward OK, with corrupted parity on a share of reads. Directed accesses add the extreme data words, the longest turnaround, an all-zero acknowledge and a mid-request `start` pulse.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN_A,
    PH_ACK,
    PH_TRN_B,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  localparam int          REQ_BITS = 8;
  localparam int          ACK_BITS = 3;
  localparam logic [2:0]  ACK_OK   = 3'b001;

  // Header: start(1), bank, dir, A2, A3, parity, stop(0), park(1), LSB first
  function automatic logic [7:0] req_pkt(input logic bank, input logic rnw,
                                         input logic [1:0] a);
    logic p;
    p = bank ^ rnw ^ a[0] ^ a[1];
    return {1'b1, 1'b0, p, a[1], a[0], rnw, bank, 1'b1};
  endfunction

endpackage

// File: rtl/swd_tx_shift.sv
module swd_tx_shift #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {1'b0, q[W-1:1]};
  end

  assign bit_out = q[0];
endmodule

// File: rtl/swd_rx_shift.sv
module swd_rx_shift #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  // Bits arrive LSB first and enter at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/swd_phase_fsm.sv
module swd_phase_fsm
  import swd_seq_pkg::*;
#(
  parameter int FRAME = 33,
  parameter int TRN_W = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rnw,
  input  logic [TRN_W-1:0] trn_len,
  input  logic [2:0]       ack_now,
  output phase_e           phase,
  output logic             start_fire,
  output logic             last,
  output logic             finish
);
  logic [CNT_W-1:0] cnt;
  logic             rnw_q;
  logic [TRN_W-1:0] trn_q;
  logic             to_wr;

  assign start_fire = start && (phase == PH_IDLE);
  assign last       = (cnt == '0);
  assign finish     = last && ((phase == PH_WDATA) ||
                               (phase == PH_TRN_B && !to_wr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rnw_q <= 1'b0;
      trn_q <= '0;
      to_wr <= 1'b0;
    end else begin
      if (phase != PH_IDLE && !last) cnt <= cnt - 1'b1;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_REQ;
          cnt   <= CNT_W'(REQ_BITS - 1);
          rnw_q <= rnw;
          trn_q <= trn_len;
        end
        PH_REQ: if (last) begin
          phase <= PH_TRN_A;
          cnt   <= CNT_W'(trn_q);
        end
        PH_TRN_A: if (last) begin
          phase <= PH_ACK;
          cnt   <= CNT_W'(ACK_BITS - 1);
        end
        PH_ACK: if (last) begin
          if (ack_now == ACK_OK && rnw_q) begin
            phase <= PH_RDATA;
            cnt   <= CNT_W'(FRAME - 1);
          end else begin
            phase <= PH_TRN_B;
            cnt   <= CNT_W'(trn_q);
            to_wr <= (ack_now == ACK_OK);
          end
        end
        PH_RDATA: if (last) begin
          phase <= PH_TRN_B;
          cnt   <= CNT_W'(trn_q);
          to_wr <= 1'b0;
        end
        PH_TRN_B: if (last) begin
          if (to_wr) begin
            phase <= PH_WDATA;
            cnt   <= CNT_W'(FRAME - 1);
          end else begin
            phase <= PH_IDLE;
          end
        end
        PH_WDATA: if (last) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swd_access_seq.sv
module swd_access_seq
  import swd_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TRN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ap_sel,
  input  logic              rd_nwr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TRN_W-1:0]  trn_len,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  output logic              busy,
  output logic [2:0]        ack,
  output logic [DATA_W-1:0] rdata,
  output logic              par_err,
  output logic              done
);
  localparam int FRAME = DATA_W + 1;
  localparam int CNT_W = $clog2(FRAME) > TRN_W ? $clog2(FRAME) : TRN_W + 1;

  phase_e            phase;
  logic              start_fire, last, finish;
  logic              tx_bit, tx_load, tx_shift;
  logic [FRAME-1:0]  tx_val, rx_q, rx_frame;
  logic [2:0]        ack_now;
  logic              ack_last, ack_ok, rd_last, in_trn;
  logic [DATA_W-1:0] wdata_q;

  // Named internal events
  assign ack_now  = {dio_in, rx_q[FRAME-1], rx_q[FRAME-2]};
  assign ack_last = (phase == PH_ACK) && last;
  assign ack_ok   = (ack_now == ACK_OK);
  assign rd_last  = (phase == PH_RDATA) && last;
  assign in_trn   = (phase == PH_TRN_A) || (phase == PH_TRN_B);
  assign rx_frame = {dio_in, rx_q[FRAME-1:1]};

  assign tx_load  = start_fire || (ack_last && ack_ok);
  assign tx_val   = start_fire ? FRAME'(req_pkt(ap_sel, rd_nwr, addr))
                               : {^wdata_q, wdata_q};
  assign tx_shift = (phase == PH_REQ) || (phase == PH_WDATA);

  swd_phase_fsm #(.FRAME(FRAME), .TRN_W(TRN_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rnw(rd_nwr),
    .trn_len(trn_len), .ack_now(ack_now), .phase(phase),
    .start_fire(start_fire), .last(last), .finish(finish)
  );

  swd_tx_shift #(.W(FRAME)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(tx_val),
    .shift(tx_shift), .bit_out(tx_bit)
  );

  swd_rx_shift #(.W(FRAME)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .shift((phase == PH_ACK) || (phase == PH_RDATA)),
    .din(dio_in), .q(rx_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      ack     <= '0;
      rdata   <= '0;
      par_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (start_fire) begin
        wdata_q <= wdata;
        par_err <= 1'b0;
      end
      if (ack_last) ack <= ack_now;
      if (rd_last) begin
        rdata   <= rx_frame[DATA_W-1:0];
        par_err <= rx_frame[DATA_W] ^ (^rx_frame[DATA_W-1:0]);
      end
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign dio_oe  = (phase == PH_IDLE) || tx_shift;
  assign dio_out = tx_shift && tx_bit;
endmodule

// File: rtl/swd_access_seq_chk.sv
module swd_access_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic finish,
  input logic dio_oe,
  input logic dio_out,
  input logic par_err,
  input logic in_trn,
  input logic rd_last,
  input logic ack_last,
  input logic ack_ok
);
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  a_r11_idle_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dio_oe && !dio_out));

  a_r3_trn_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_trn |-> !dio_oe);

  a_r7_perr_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> $past(rd_last));

  a_r8_fail_skips_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_last && !ack_ok) |=> in_trn);
endmodule

bind swd_access_seq swd_access_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .finish(finish),
  .dio_oe(dio_oe), .dio_out(dio_out), .par_err(par_err), .in_trn(in_trn),
  .rd_last(rd_last), .ack_last(ack_last), .ack_ok(ack_ok)
);

// File: tb/swd_access_seq_test.sv
module swd_access_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ap_sel = 1'b0, rd_nwr = 1'b0;
  logic [1:0]  addr = '0, trn_len = '0;
  logic [31:0] wdata = '0;
  logic        dio_in = 1'b0;
  logic        dio_out, dio_oe, busy, par_err, done;
  logic [2:0]  ack;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] exp_rdata = '0;

  always #2.5 clk = ~clk;

  swd_access_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ap_sel(ap_sel),
    .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata), .trn_len(trn_len),
    .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe), .busy(busy),
    .ack(ack), .rdata(rdata), .par_err(par_err), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ones_odd(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n++;
    return (n % 2) == 1;
  endfunction

  function automatic logic [7:0] model_req(input logic b, input logic r,
                                           input logic [1:0] a);
    logic [7:0] h = 8'h81;
    int n = 0;
    h[1] = b; h[2] = r; h[3] = a[0]; h[4] = a[1];
    for (int i = 1; i <= 4; i++) if (h[i]) n++;
    h[5] = (n % 2 == 1);
    return h;
  endfunction

  task automatic trn_span(input int len, inout int bad, inout int bbusy);
    for (int t = 0; t < len; t++) begin
      if (dio_oe) bad++;
      if (!busy) bbusy++;
      @(negedge clk);
    end
  endtask

  task automatic access(input logic b, input logic r, input logic [1:0] a,
                        input logic [31:0] wd, input logic [1:0] tl,
                        input logic [2:0] ackv, input logic [32:0] rframe,
                        input bit inject);
    logic [7:0]  hdr = model_req(b, r, a);
    logic [32:0] wframe = {ones_odd(wd), wd};
    int bad_req = 0, bad_trn = 0, bad_ack = 0, bad_dat = 0, bad_busy = 0;
    bit ok = (ackv == 3'b001);
    @(negedge clk);
    ap_sel = b; rd_nwr = r; addr = a; wdata = wd; trn_len = tl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!dio_oe || dio_out !== hdr[i]) bad_req++;
      if (!busy || done) bad_busy++;
      if (inject && i == 3) begin
        start = 1'b1; ap_sel = ~b; rd_nwr = ~r; addr = ~a; wdata = ~wd;
        trn_len = ~tl;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    trn_span(tl + 1, bad_trn, bad_busy);
    for (int k = 0; k < 3; k++) begin
      dio_in = ackv[k];
      if (dio_oe) bad_ack++;
      if (!busy) bad_busy++;
      @(negedge clk);
    end
    dio_in = 1'b0;
    if (ok && !r) begin
      trn_span(tl + 1, bad_trn, bad_busy);
      for (int i = 0; i < 33; i++) begin
        if (!dio_oe || dio_out !== wframe[i]) bad_dat++;
        if (!busy) bad_busy++;
        @(negedge clk);
      end
    end else if (ok && r) begin
      for (int i = 0; i < 33; i++) begin
        dio_in = rframe[i];
        if (dio_oe) bad_dat++;
        if (!busy) bad_busy++;
        @(negedge clk);
      end
      dio_in = 1'b0;
      trn_span(tl + 1, bad_trn, bad_busy);
    end else begin
      trn_span(tl + 1, bad_trn, bad_busy);
    end
    if (ok && r) exp_rdata = rframe[31:0];
    check(bad_req == 0, "R1/R2 header bits", bad_req, 0);
    check(bad_trn == 0, "R3 turnaround released", bad_trn, 0);
    check(bad_ack == 0, "R4 line released during ack", bad_ack, 0);
    if (ok && !r) check(bad_dat == 0, "R5 write frame", bad_dat, 0);
    if (ok && r)  check(bad_dat == 0, "R6 read released", bad_dat, 0);
    check(bad_busy == 0, "R9 busy during access", bad_busy, 0);
    check(done === 1'b1 && busy === 1'b0, "R9 done at end", done, 1);
    check(ack === ackv, "R4 ack value", ack, ackv);
    if (ok && r)
      check(rdata === exp_rdata, "R6 read data", rdata, exp_rdata);
    else
      check(rdata === exp_rdata, "R8 rdata unchanged", rdata, exp_rdata);
    check(par_err === (ok && r && (rframe[32] != ones_odd(rframe[31:0]))),
          "R7 parity flag", par_err, ok && r && (rframe[32] != ones_odd(rframe[31:0])));
    if (inject) check(bad_req == 0 && bad_busy == 0, "R10 start ignored", bad_req, 0);
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", done, 0);
    check(dio_oe === 1'b1 && dio_out === 1'b0, "R11 idle drive", {dio_oe, dio_out}, 2);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] fr;
    logic [2:0]  av;
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check(busy === 0 && done === 0 && ack === 0 && rdata === 0 && par_err === 0,
          "R11 reset state", {busy, done, ack, par_err}, 0);
    check(dio_oe === 1'b1 && dio_out === 1'b0, "R11 reset idle drive",
          {dio_oe, dio_out}, 2);
    rst_n = 1'b1;
    // Directed corners
    access(1'b0, 1'b0, 2'b00, 32'h0000_0000, 2'd0, 3'b001, '0, 0);
    access(1'b1, 1'b0, 2'b11, 32'hFFFF_FFFF, 2'd3, 3'b001, '0, 0);
    access(1'b1, 1'b1, 2'b01, 32'h0, 2'd1, 3'b001, {1'b1, 32'h8000_0001}, 0);
    access(1'b0, 1'b1, 2'b10, 32'h0, 2'd2, 3'b001, {1'b1, 32'h0000_0007}, 0);
    access(1'b1, 1'b1, 2'b10, 32'h0, 2'd0, 3'b100, {1'b0, 32'h1234_5678}, 0);
    access(1'b0, 1'b0, 2'b01, 32'hA5A5_0001, 2'd1, 3'b010, '0, 0);
    access(1'b0, 1'b1, 2'b00, 32'h0, 2'd3, 3'b000, '0, 0);
    access(1'b1, 1'b0, 2'b10, 32'hDEAD_BEEF, 2'd2, 3'b001, '0, 1);
    // Random mix
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom % 8;
      av = (sel < 5) ? 3'b001 : (sel == 5) ? 3'b010 : (sel == 6) ? 3'b100
                     : 3'($urandom);
      fr[31:0] = $urandom;
      fr[32] = ones_odd(fr[31:0]) ^ (($urandom % 4) == 0);
      access(1'($urandom), 1'($urandom), 2'($urandom), $urandom,
             2'($urandom), av, fr, ($urandom % 10) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule